// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the per-thread control machine of a superscalar register-rename stage. Every cycle it decides how many of the instructions offered by decode may be renamed and forwarded. It weighs the free entries left in the reorder buffer, issue queue and load-store queue against the instructions it wants to send. It also honours stall requests from execute and commit, restarts after a squash, and holds back barrier instructions until the back end has drained. Register mapping is not part of this block.

Instructions that cannot go forward are held in a skid buffer, which keeps only an instruction count. While the stage is blocked, serialising or draining, decode is told to hold off. It is released only when the skid buffer has emptied. Free counts from the back end arrive late, so the block keeps its own count of instructions sent since the last occupancy update and subtracts it from each free count.

State encoding (output `fsm_state`): RUN=0, IDLE=1, SQ_START=2, SQUASH=3, BLOCK=4, UNBLK=5, SER=6. Transitions:
- RUN/IDLE→IDLE when nothing arrives.
- RUN/IDLE→BLOCK on a stall request or a shortfall.
- RUN/IDLE→SER on a barrier.
- RUN/IDLE→RUN when the group is granted.
- BLOCK→UNBLK once there is room and no stall.
- SER→UNBLK once the back end is drained.
- UNBLK→BLOCK on a stall request or a shortfall.
- UNBLK→RUN when the skid buffer empties.
- Any state→SQ_START on squash.
- SQ_START→SQUASH, then SQUASH→IDLE.

Top module: `rename_stall_ctrl`

## Requirements
- R1: After reset the state is IDLE (1), `grant` is 0, `dec_block` is 0 and `full_cause` is NONE (0).
- R2: In RUN or IDLE, when no stall is requested, no barrier applies and all three structures have room, `grant` equals `dec_count` (never above WIDTH), and the state becomes RUN.
- R3: A structure lacks room when its free count minus the effective in-flight count is below the wanted count. `full_cause` reports the first lacking one in the order ROB (1), IQ (2), LSQ (3), else NONE (0). It is shown only in RUN, IDLE, BLOCK or UNBLK with no squash and no stall request. A shortfall in RUN/IDLE moves to BLOCK with the whole group in the skid buffer.
- R4: A stall request from execute or from commit gives `grant`=0. In RUN/IDLE with instructions arriving, or in UNBLK, it moves to BLOCK.
- R5: `dec_block` is 1 exactly in SQ_START, SQUASH, BLOCK, UNBLK and SER. In BLOCK, SER and UNBLK an arriving group enters the skid buffer only if the total stays within SKID_DEPTH. Otherwise the whole group is ignored.
- R6: BLOCK moves to UNBLK when no stall is requested and the first min(skid, WIDTH) instructions fit. UNBLK grants min(skid, WIDTH) per cycle and returns to RUN only when the skid buffer is empty.
- R7: The effective in-flight count is 0 in a cycle with `occ_update`=1, else the sum of grants since the last update (saturating). It is reduced from every free count.
- R8: In RUN/IDLE, an arriving group with `dec_barrier` (and no stall request) goes into the skid buffer with `grant`=0 and the state moves to SER. SER moves to UNBLK only when `rob_empty` is 1 and the effective in-flight count is 0.
- R9: An accepted group with `dec_ser_after` sets a pending flag. The next group taken directly from decode in RUN/IDLE is then treated as a barrier, which clears the flag.
- R10: `squash` in any state moves to SQ_START, empties the skid buffer and clears the pending flag. SQ_START lasts one cycle, then SQUASH lasts one cycle, then IDLE. Arrivals in both squash states are dropped and `grant` is 0.
- R11: In RUN or IDLE with `dec_count`=0 and no squash, the next state is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_count | input | CW | Instructions offered by decode this cycle (0..WIDTH) |
| dec_barrier | input | 1 | Oldest offered instruction must serialise |
| dec_ser_after | input | 1 | Youngest offered instruction serialises the next one |
| rob_free | input | FW | Free reorder-buffer entries |
| iq_free | input | FW | Free issue-queue entries |
| lsq_free | input | FW | Free load-store-queue entries |
| occ_update | input | 1 | Free counts this cycle include all earlier sends |
| stall_exec | input | 1 | Stall request from execute |
| stall_commit | input | 1 | Stall request from commit |
| squash | input | 1 | Flush request |
| rob_empty | input | 1 | Reorder buffer is empty |
| grant | output | CW | Instructions renamed this cycle |
| dec_block | output | 1 | Tell decode to hold off |
| full_cause | output | 2 | Structure-full cause (NONE/ROB/IQ/LSQ) |
| fsm_state | output | 3 | Current state |

## Verification
On every cycle, the assertions check the squash entry and its fixed two-cycle exit, zero grant during stall requests and squash states, the grant cap, and that SER holds while the reorder buffer is not empty. The bench's cycle model alone can show the effects that depend on history: the skid count across block/unblock episodes, the in-flight subtraction between occupancy updates, the cause priority, and a pending serialise-after being consumed by a later group.

// File: rtl/rn_ctrl_pkg.sv
`timescale 1ns/1ps
package rn_ctrl_pkg;
    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_IDLE     = 3'd1,
        ST_SQ_START = 3'd2,
        ST_SQUASH   = 3'd3,
        ST_BLOCK    = 3'd4,
        ST_UNBLK    = 3'd5,
        ST_SER      = 3'd6
    } rn_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_ROB  = 2'd1,
        CAUSE_IQ   = 2'd2,
        CAUSE_LSQ  = 2'd3
    } rn_cause_e;
endpackage

// File: rtl/rn_full_pick.sv
`timescale 1ns/1ps
module rn_full_pick
    import rn_ctrl_pkg::*;
#(
    parameter int FW = 6,
    parameter int IW = 7,
    parameter int CW = 3
) (
    input  logic [2:0][FW-1:0] free_all,
    input  logic [IW-1:0]      feff,
    input  logic [CW-1:0]      want,
    output logic               lack_any,
    output rn_cause_e          cause
);
    localparam int SW = IW + 1;

    logic [2:0] lack;
    logic [SW-1:0] need;

    assign need = {1'b0, feff} + SW'(want);

    for (genvar i = 0; i < 3; i++) begin : g_struct
        assign lack[i] = (want != '0) && (SW'(free_all[i]) < need);
    end

    assign lack_any = |lack;

    always_comb begin
        if (lack[0])      cause = CAUSE_ROB;
        else if (lack[1]) cause = CAUSE_IQ;
        else if (lack[2]) cause = CAUSE_LSQ;
        else              cause = CAUSE_NONE;
    end
endmodule

// File: rtl/rn_inflight.sv
`timescale 1ns/1ps
module rn_inflight #(
    parameter int IW = 7,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fresh,
    input  logic [CW-1:0] sent,
    output logic [IW-1:0] feff
);
    logic [IW-1:0] cnt;
    logic [IW:0]   sum;

    assign feff = fresh ? '0 : cnt;
    assign sum  = {1'b0, feff} + (IW+1)'(sent);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (sum[IW]) cnt <= '1;
        else             cnt <= sum[IW-1:0];
    end
endmodule

// File: rtl/rename_stall_ctrl.sv
`timescale 1ns/1ps
module rename_stall_ctrl
    import rn_ctrl_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter int SKID_DEPTH = 8,
    parameter int FW         = 6,
    parameter int CW         = $clog2(WIDTH + 1),
    parameter int KW         = $clog2(SKID_DEPTH + 1),
    parameter int IW         = FW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] dec_count,
    input  logic          dec_barrier,
    input  logic          dec_ser_after,
    input  logic [FW-1:0] rob_free,
    input  logic [FW-1:0] iq_free,
    input  logic [FW-1:0] lsq_free,
    input  logic          occ_update,
    input  logic          stall_exec,
    input  logic          stall_commit,
    input  logic          squash,
    input  logic          rob_empty,
    output logic [CW-1:0] grant,
    output logic          dec_block,
    output logic [1:0]    full_cause,
    output logic [2:0]    fsm_state
);
    rn_state_e     st, st_n;
    logic [KW-1:0] skid, skid_n;
    logic          pend, pend_n;
    logic [CW-1:0] grant_c;
    logic [CW-1:0] want_c;
    logic [IW-1:0] feff;
    logic          lack_any;
    rn_cause_e     cause_c;
    logic          busy, direct, room, eval_ok;
    logic [CW-1:0] app;
    logic [KW:0]   skid_app, skid_drain;

    rn_inflight #(.IW(IW), .CW(CW)) u_infl (
        .clk   (clk),
        .rst_n (rst_n),
        .fresh (occ_update),
        .sent  (grant_c),
        .feff  (feff)
    );

    rn_full_pick #(.FW(FW), .IW(IW), .CW(CW)) u_pick (
        .free_all ({lsq_free, iq_free, rob_free}),
        .feff     (feff),
        .want     (want_c),
        .lack_any (lack_any),
        .cause    (cause_c)
    );

    assign busy   = stall_exec | stall_commit;
    assign direct = (st == ST_RUN) || (st == ST_IDLE);

    always_comb begin
        if (direct)                       want_c = dec_count;
        else if (skid > KW'(WIDTH))       want_c = CW'(WIDTH);
        else                              want_c = skid[CW-1:0];
    end

    assign room       = ({1'b0, skid} + (KW+1)'(dec_count)) <= (KW+1)'(SKID_DEPTH);
    assign app        = room ? dec_count : '0;
    assign skid_app   = {1'b0, skid} + (KW+1)'(app);
    assign skid_drain = skid_app - (KW+1)'(want_c);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            skid <= '0;
            pend <= 1'b0;
        end else begin
            st   <= st_n;
            skid <= skid_n;
            pend <= pend_n;
        end
    end

    // next state and grant
    always_comb begin
        st_n    = st;
        skid_n  = skid;
        pend_n  = pend;
        grant_c = '0;
        if (squash) begin
            st_n   = ST_SQ_START;
            skid_n = '0;
            pend_n = 1'b0;
        end else begin
            unique case (st)
                ST_SQ_START: st_n = ST_SQUASH;
                ST_SQUASH:   st_n = ST_IDLE;
                ST_RUN, ST_IDLE: begin
                    if (dec_count == '0) begin
                        st_n = ST_IDLE;
                    end else if (busy) begin
                        st_n   = ST_BLOCK;
                        skid_n = KW'(dec_count);
                        pend_n = pend | dec_ser_after;
                    end else if (dec_barrier || pend) begin
                        st_n   = ST_SER;
                        skid_n = KW'(dec_count);
                        pend_n = dec_ser_after;
                    end else if (lack_any) begin
                        st_n   = ST_BLOCK;
                        skid_n = KW'(dec_count);
                        pend_n = pend | dec_ser_after;
                    end else begin
                        st_n    = ST_RUN;
                        grant_c = dec_count;
                        pend_n  = dec_ser_after;
                    end
                end
                ST_BLOCK: begin
                    skid_n = skid_app[KW-1:0];
                    if (app != '0) pend_n = pend | dec_ser_after;
                    if (!busy && !lack_any) st_n = ST_UNBLK;
                end
                ST_SER: begin
                    skid_n = skid_app[KW-1:0];
                    if (app != '0) pend_n = pend | dec_ser_after;
                    if (rob_empty && (feff == '0)) st_n = ST_UNBLK;
                end
                ST_UNBLK: begin
                    if (app != '0) pend_n = pend | dec_ser_after;
                    if (busy || lack_any) begin
                        st_n   = ST_BLOCK;
                        skid_n = skid_app[KW-1:0];
                    end else begin
                        grant_c = want_c;
                        skid_n  = skid_drain[KW-1:0];
                        st_n    = (skid_drain == '0) ? ST_RUN : ST_UNBLK;
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        eval_ok    = (direct || st == ST_BLOCK || st == ST_UNBLK) && !squash && !busy;
        grant      = grant_c;
        full_cause = eval_ok ? cause_c : CAUSE_NONE;
        dec_block  = (st == ST_SQ_START) || (st == ST_SQUASH) || (st == ST_BLOCK) ||
                     (st == ST_UNBLK) || (st == ST_SER);
        fsm_state  = st;
    end
endmodule

// File: rtl/rn_ctrl_chk.sv
`timescale 1ns/1ps
module rn_ctrl_chk
    import rn_ctrl_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          squash,
    input logic          stall_exec,
    input logic          stall_commit,
    input logic          rob_empty,
    input logic [CW-1:0] grant,
    input logic [2:0]    fsm_state
);
    p_squash_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> fsm_state == ST_SQ_START);

    p_squash_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_SQ_START && !squash) |=> fsm_state == ST_SQUASH);

    p_squash_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_SQUASH && !squash) |=> fsm_state == ST_IDLE);

    p_squash_nogrant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_SQ_START || fsm_state == ST_SQUASH) |-> grant == '0);

    p_stall_nogrant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_exec || stall_commit) |-> grant == '0);

    p_grant_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant <= CW'(WIDTH));

    p_ser_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_SER && !rob_empty && !squash) |=> fsm_state == ST_SER);
endmodule

bind rename_stall_ctrl rn_ctrl_chk #(.WIDTH(WIDTH), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .squash       (squash),
    .stall_exec   (stall_exec),
    .stall_commit (stall_commit),
    .rob_empty    (rob_empty),
    .grant        (grant),
    .fsm_state    (fsm_state)
);

// File: tb/rename_stall_ctrl_tb.sv
`timescale 1ns/1ps
module rename_stall_ctrl_tb;
    localparam int W  = 4;
    localparam int D  = 8;
    localparam int FW = 6;
    localparam int CW = $clog2(W + 1);
    localparam int IMAX = (1 << (FW + 1)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] dec_count = '0;
    logic dec_barrier = 1'b0, dec_ser_after = 1'b0;
    logic [FW-1:0] rob_free = '0, iq_free = '0, lsq_free = '0;
    logic occ_update = 1'b0, stall_exec = 1'b0, stall_commit = 1'b0;
    logic squash = 1'b0, rob_empty = 1'b0;
    logic [CW-1:0] grant;
    logic dec_block;
    logic [1:0] full_cause;
    logic [2:0] fsm_state;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    int ms = 1, mk = 0, mf = 0, mp = 0;
    int ns, nk, nf, np;
    int m_grant, m_cause, m_block;
    string tag;

    always #10 clk = ~clk;

    rename_stall_ctrl #(.WIDTH(W), .SKID_DEPTH(D), .FW(FW)) u_dut (
        .clk(clk), .rst_n(rst_n), .dec_count(dec_count), .dec_barrier(dec_barrier),
        .dec_ser_after(dec_ser_after), .rob_free(rob_free), .iq_free(iq_free),
        .lsq_free(lsq_free), .occ_update(occ_update), .stall_exec(stall_exec),
        .stall_commit(stall_commit), .squash(squash), .rob_empty(rob_empty),
        .grant(grant), .dec_block(dec_block), .full_cause(full_cause),
        .fsm_state(fsm_state)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic model_eval();
        int feff, want, busy, cause, app, n;
        n = int'(dec_count);
        feff = occ_update ? 0 : mf;
        busy = int'(stall_exec | stall_commit);
        want = (ms <= 1) ? n : ((mk > W) ? W : mk);
        cause = 0;
        if (want > 0) begin
            if (int'(rob_free) < feff + want)      cause = 1;
            else if (int'(iq_free) < feff + want)  cause = 2;
            else if (int'(lsq_free) < feff + want) cause = 3;
        end
        m_cause = ((ms == 0 || ms == 1 || ms == 4 || ms == 5) && !squash && !busy) ? cause : 0;
        m_block = (ms >= 2) ? 1 : 0;
        app = (mk + n <= D) ? n : 0;
        ns = ms; nk = mk; np = mp; m_grant = 0; tag = "R1";
        if (squash) begin
            ns = 2; nk = 0; np = 0; tag = "R10";
        end else if (ms == 2) begin
            ns = 3; tag = "R10";
        end else if (ms == 3) begin
            ns = 1; tag = "R10";
        end else if (ms <= 1) begin
            if (n == 0) begin
                ns = 1; tag = "R11";
            end else if (busy) begin
                ns = 4; nk = n; np = mp | dec_ser_after; tag = "R4";
            end else if (dec_barrier || mp) begin
                ns = 6; nk = n; np = dec_ser_after; tag = mp ? "R9" : "R8";
            end else if (cause != 0) begin
                ns = 4; nk = n; np = dec_ser_after; tag = "R3";
            end else begin
                ns = 0; m_grant = n; np = dec_ser_after; tag = "R2";
            end
        end else begin
            if (app != 0) np = mp | dec_ser_after;
            if (ms == 4) begin
                nk = mk + app; tag = "R5";
                if (!busy && cause == 0) begin ns = 5; tag = "R6"; end
            end else if (ms == 6) begin
                nk = mk + app; tag = "R8";
                if (rob_empty && feff == 0) ns = 5;
            end else begin
                tag = "R6";
                if (busy || cause != 0) begin
                    ns = 4; nk = mk + app;
                end else begin
                    m_grant = want; nk = mk - want + app;
                    ns = (nk == 0) ? 0 : 5;
                end
            end
        end
        nf = feff + m_grant;
        if (nf > IMAX) nf = IMAX;
    endtask

    task automatic drive_random();
        dec_count     = CW'($urandom_range(0, W));
        dec_barrier   = ($urandom_range(0, 11) == 0);
        dec_ser_after = ($urandom_range(0, 11) == 0);
        rob_free = ($urandom_range(0, 3) == 0) ? FW'($urandom_range(0, 6)) : FW'($urandom_range(7, 63));
        iq_free  = ($urandom_range(0, 3) == 0) ? FW'($urandom_range(0, 6)) : FW'($urandom_range(7, 63));
        lsq_free = ($urandom_range(0, 3) == 0) ? FW'($urandom_range(0, 6)) : FW'($urandom_range(7, 63));
        occ_update   = ($urandom_range(0, 2) == 0);
        stall_exec   = ($urandom_range(0, 14) == 0);
        stall_commit = ($urandom_range(0, 14) == 0);
        squash       = ($urandom_range(0, 39) == 0);
        rob_empty    = ($urandom_range(0, 2) != 0);
    endtask

    task automatic step_and_compare();
        #5;
        model_eval();
        check({"state ", tag}, int'(fsm_state), ms);
        check({"grant R7 ", tag}, int'(grant), m_grant);
        check("cause R3", int'(full_cause), m_cause);
        check("block R5", int'(dec_block), m_block);
        ms = ns; mk = nk; mf = nf; mp = np;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("reset state R1", int'(fsm_state), 1);
        check("reset grant R1", int'(grant), 0);
        check("reset block R1", int'(dec_block), 0);
        check("reset cause R1", int'(full_cause), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 6000; c++) begin
            if (c > 0) @(negedge clk);
            if (c < 400) begin
                // phase with plenty of room: mostly direct grants (R2, R11)
                drive_random();
                rob_free = 6'd63; iq_free = 6'd63; lsq_free = 6'd63;
                squash = 1'b0;
            end else if (c < 800) begin
                // heavy stalls and tight structures: skid fill and drain (R5, R6)
                drive_random();
                stall_exec = ($urandom_range(0, 3) == 0);
                occ_update = ($urandom_range(0, 5) == 0);
                squash = 1'b0;
            end else begin
                drive_random();
            end
            step_and_compare();
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule